// File: doc/BRIEF.md
# Receive Error Event Counter Bank with Shadow Buffers

This block tallies receive-side error events for a T1/J1 framer. Four 16-bit counters track code violations, framing bit errors, CRC6 errors and errored blocks. A fifth, shared counter holds two fields: a 6-bit count of multiframes received while out of alignment, and a 2-bit count of frame alignment changes. Event detection happens upstream. Each input is a one-cycle pulse, and every cycle in which a pulse is high adds one to its counter.

Each live counter has a shadow buffer, and software reads only the buffers. A single latch event copies all live counts into their buffers and clears the live counts in the same edge. The latch source depends on the mode. In periodic mode it is a one-second tick. In on-demand mode it is a software request strobe, which is answered by an acknowledge flag. The counters stop at their maximum value instead of wrapping. An event that lands on the latch edge starts the new period with a count of one, so no event is lost.

Top module: `errcnt_bank`

## Requirements
- R1: Each wide counter adds one per clock cycle in which its event input is high. After a latch, its buffer output shows the number of such cycles since the previous latch, up to saturation.
- R2: `combo_buf_o[5:0]` holds the out-of-alignment multiframe count and `combo_buf_o[7:6]` holds the alignment-change count. Each field counts only its own event input.
- R3: A wide counter that reaches 65535 stays at 65535 on further events until the next latch.
- R4: The 6-bit field stops at 63 and the 2-bit field stops at 3. Each saturates without disturbing the other.
- R5: With `mode_demand_i` = 0, a cycle with `sec_tick_i` high copies every live count into its buffer and restarts counting from zero.
- R6: With `mode_demand_i` = 1, a cycle with `req_i` high performs the same copy and clear. `sec_tick_i` has no effect on the buffers in this mode.
- R7: With `mode_demand_i` = 0, `req_i` has no effect on the buffers, and `ack_o` is held low from the following cycle.
- R8: An event in the same cycle as a latch is left out of the copied value and appears as a count of one in the next period.
- R9: In on-demand mode, `ack_o` is low on the edge that samples a request and rises on the following edge. It stays high until the next request is sampled, and that edge clears it.
- R10: After reset every buffer reads zero and `ack_o` is low. Buffers keep their value between latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_ev_i | input | 1 | Code violation event pulse |
| fbit_ev_i | input | 1 | Framing bit error event pulse |
| crc_ev_i | input | 1 | CRC6 error event pulse |
| eblk_ev_i | input | 1 | Errored block event pulse |
| mfa_ev_i | input | 1 | Multiframe received out of alignment |
| cofa_ev_i | input | 1 | Change of frame alignment |
| sec_tick_i | input | 1 | One-second tick, used in periodic mode |
| mode_demand_i | input | 1 | 0 = periodic latching, 1 = on-demand latching |
| req_i | input | 1 | Software latch request strobe |
| ack_o | output | 1 | Request acknowledge flag |
| cv_buf_o | output | 16 | Buffered code violation count |
| fbit_buf_o | output | 16 | Buffered framing bit error count |
| crc_buf_o | output | 16 | Buffered CRC6 error count |
| eblk_buf_o | output | 16 | Buffered errored block count |
| combo_buf_o | output | 8 | Buffered shared count: [7:6] alignment changes, [5:0] async multiframes |

## Verification
The bench drives more than 65535 code-violation events into one period and overfills both fields of the shared counter. A wrapping counter would show a small remainder here, and a field that carries into its neighbour would corrupt the other count. It raises an event in the same cycle as a tick and again with a request. A design that loses that event would read zero in the next period, and one that lets it leak into the copy would read one too many. It also sends requests in periodic mode and ticks in on-demand mode. A design that honoured the wrong source would overwrite the buffers or raise the acknowledge at the wrong time.

// File: rtl/errcnt_pkg.sv
`timescale 1ns/1ps
package errcnt_pkg;
   // number of full-width event counters in the bank
   localparam int unsigned NUM_WIDE = 4;

   // latch source selection
   typedef enum logic {
      MODE_SECOND = 1'b0,
      MODE_DEMAND = 1'b1
   } latch_mode_e;
endpackage

// File: rtl/errcnt_sat_field.sv
`timescale 1ns/1ps
// One saturating live counter plus its shadow buffer.
module errcnt_sat_field #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         latch_i,
   output logic [W-1:0] shadow_o
);
   localparam logic [W-1:0] MAX_V = {W{1'b1}};
   localparam logic [W-1:0] ONE_V = W'(1);

   initial begin : param_chk
      assert (W >= 1 && W <= 32) else $fatal(1, "errcnt_sat_field: W out of range");
   end

   logic [W-1:0] live_q;
   logic [W-1:0] live_inc;
   logic         at_max;

   // saturation detect: a single-bit field is full whenever it is set
   generate
      if (W == 1) begin : g_bit
         assign at_max   = live_q[0];
         assign live_inc = 1'b1;
      end else begin : g_vec
         assign at_max   = (live_q == MAX_V);
         assign live_inc = live_q + ONE_V;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q   <= '0;
         shadow_o <= '0;
      end else if (latch_i) begin
         shadow_o <= live_q;
         live_q   <= inc_i ? ONE_V : '0;
      end else if (inc_i && !at_max) begin
         live_q <= live_inc;
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q == MAX_V && !latch_i) |=> (live_q == MAX_V));
   // R8
   clear_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_i && inc_i) |=> (live_q == ONE_V));
   // R5
   shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_i |=> (shadow_o == $past(live_q)));
   // R10
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_i |=> $stable(shadow_o));
endmodule

// File: rtl/errcnt_latch_ctrl.sv
`timescale 1ns/1ps
// Chooses the latch source and runs the request/acknowledge handshake.
module errcnt_latch_ctrl
   import errcnt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_demand_i,
   input  logic sec_tick_i,
   input  logic req_i,
   output logic latch_o,
   output logic ack_o
);
   latch_mode_e mode;
   logic        pend_q;
   logic        dem_req;

   assign mode    = latch_mode_e'(mode_demand_i);
   assign dem_req = (mode == MODE_DEMAND) && req_i;
   assign latch_o = (mode == MODE_DEMAND) ? req_i : sec_tick_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         ack_o  <= 1'b0;
      end else if (mode == MODE_SECOND) begin
         pend_q <= 1'b0;
         ack_o  <= 1'b0;
      end else begin
         pend_q <= dem_req;
         if (dem_req)     ack_o <= 1'b0;
         else if (pend_q) ack_o <= 1'b1;
      end
   end

   // R7
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_demand_i |=> !ack_o);
   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_demand_i && req_i) |=> !ack_o);
   // R9
   ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(latch_o, 2));
endmodule

// File: rtl/errcnt_bank.sv
`timescale 1ns/1ps
module errcnt_bank
   import errcnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned MFA_W  = 6,
   parameter int unsigned COFA_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cv_ev_i,
   input  logic                      fbit_ev_i,
   input  logic                      crc_ev_i,
   input  logic                      eblk_ev_i,
   input  logic                      mfa_ev_i,
   input  logic                      cofa_ev_i,
   input  logic                      sec_tick_i,
   input  logic                      mode_demand_i,
   input  logic                      req_i,
   output logic                      ack_o,
   output logic [CNT_W-1:0]          cv_buf_o,
   output logic [CNT_W-1:0]          fbit_buf_o,
   output logic [CNT_W-1:0]          crc_buf_o,
   output logic [CNT_W-1:0]          eblk_buf_o,
   output logic [MFA_W+COFA_W-1:0]   combo_buf_o
);
   localparam int unsigned COMBO_W = MFA_W + COFA_W;

   initial begin : param_chk
      assert (CNT_W >= 2 && CNT_W <= 32) else $fatal(1, "errcnt_bank: CNT_W out of range");
      assert (MFA_W >= 1 && COFA_W >= 1 && COMBO_W <= 32)
         else $fatal(1, "errcnt_bank: shared counter widths out of range");
   end

   logic                latch;
   logic [NUM_WIDE-1:0] wide_ev;
   logic [CNT_W-1:0]    wide_buf [NUM_WIDE];
   logic [MFA_W-1:0]    mfa_buf;
   logic [COFA_W-1:0]   cofa_buf;

   assign wide_ev = {eblk_ev_i, crc_ev_i, fbit_ev_i, cv_ev_i};

   errcnt_latch_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_demand_i (mode_demand_i),
      .sec_tick_i    (sec_tick_i),
      .req_i         (req_i),
      .latch_o       (latch),
      .ack_o         (ack_o)
   );

   generate
      for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
         errcnt_sat_field #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (wide_ev[i]),
            .latch_i  (latch),
            .shadow_o (wide_buf[i])
         );
      end
   endgenerate

   errcnt_sat_field #(.W(MFA_W)) u_mfa (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (mfa_ev_i),
      .latch_i  (latch),
      .shadow_o (mfa_buf)
   );

   errcnt_sat_field #(.W(COFA_W)) u_cofa (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (cofa_ev_i),
      .latch_i  (latch),
      .shadow_o (cofa_buf)
   );

   assign cv_buf_o    = wide_buf[0];
   assign fbit_buf_o  = wide_buf[1];
   assign crc_buf_o   = wide_buf[2];
   assign eblk_buf_o  = wide_buf[3];
   // R2: alignment-change field on top, async multiframes below
   assign combo_buf_o = {cofa_buf, mfa_buf};
endmodule

// File: tb/tb_errcnt_bank.sv
`timescale 1ns/1ps
module tb_errcnt_bank;
   logic clk = 1'b0;
   logic rst_n;
   logic cv_ev, fbit_ev, crc_ev, eblk_ev, mfa_ev, cofa_ev;
   logic tick, mode_dem, req;
   logic ack;
   logic [15:0] cv_buf, fbit_buf, crc_buf, eblk_buf;
   logic [7:0]  combo_buf;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   errcnt_bank dut (
      .clk(clk), .rst_n(rst_n),
      .cv_ev_i(cv_ev), .fbit_ev_i(fbit_ev), .crc_ev_i(crc_ev), .eblk_ev_i(eblk_ev),
      .mfa_ev_i(mfa_ev), .cofa_ev_i(cofa_ev),
      .sec_tick_i(tick), .mode_demand_i(mode_dem), .req_i(req),
      .ack_o(ack),
      .cv_buf_o(cv_buf), .fbit_buf_o(fbit_buf), .crc_buf_o(crc_buf), .eblk_buf_o(eblk_buf),
      .combo_buf_o(combo_buf)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_inputs();
      cv_ev = 0; fbit_ev = 0; crc_ev = 0; eblk_ev = 0; mfa_ev = 0; cofa_ev = 0;
      tick = 0; req = 0;
   endtask

   // drive event counts, one pulse per cycle while below each count
   task automatic pulse_events(input int ncv, input int nfb, input int ncrc,
                               input int neb, input int nmfa, input int ncofa);
      int top = ncv;
      if (nfb > top) top = nfb;
      if (ncrc > top) top = ncrc;
      if (neb > top) top = neb;
      if (nmfa > top) top = nmfa;
      if (ncofa > top) top = ncofa;
      for (int k = 0; k < top; k++) begin
         @(negedge clk);
         cv_ev = (k < ncv); fbit_ev = (k < nfb); crc_ev = (k < ncrc);
         eblk_ev = (k < neb); mfa_ev = (k < nmfa); cofa_ev = (k < ncofa);
      end
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
   endtask

   task automatic test_reset();
      chk("R10 reset cv_buf", cv_buf, 0);
      chk("R10 reset combo_buf", combo_buf, 0);
      chk("R10 reset ack", ack, 0);
   endtask

   task automatic test_periodic();
      mode_dem = 0;
      pulse_events(5, 7, 3, 11, 9, 2);
      chk("R10 no latch yet cv_buf", cv_buf, 0);
      do_tick();
      chk("R1 cv_buf", cv_buf, 5);
      chk("R1 fbit_buf", fbit_buf, 7);
      chk("R1 crc_buf", crc_buf, 3);
      chk("R1 eblk_buf", eblk_buf, 11);
      chk("R2 mfa field", combo_buf[5:0], 9);
      chk("R2 cofa field", combo_buf[7:6], 2);
      do_tick();
      chk("R5 cleared cv_buf", cv_buf, 0);
      chk("R5 cleared eblk_buf", eblk_buf, 0);
      chk("R5 cleared combo_buf", combo_buf, 0);
   endtask

   task automatic test_same_cycle_tick();
      mode_dem = 0;
      pulse_events(2, 0, 0, 0, 0, 0);
      @(negedge clk); cv_ev = 1; mfa_ev = 1; tick = 1;
      @(negedge clk); clear_inputs();
      chk("R8 tick copy excludes cv event", cv_buf, 2);
      chk("R8 tick copy excludes mfa event", combo_buf[5:0], 0);
      do_tick();
      chk("R8 cv event kept in new period", cv_buf, 1);
      chk("R8 mfa event kept in new period", combo_buf[5:0], 1);
   endtask

   task automatic test_saturation();
      mode_dem = 0;
      pulse_events(65540, 4, 0, 0, 70, 5);
      do_tick();
      chk("R3 cv saturates", cv_buf, 65535);
      chk("R1 fbit alongside", fbit_buf, 4);
      chk("R4 mfa saturates", combo_buf[5:0], 63);
      chk("R4 cofa saturates", combo_buf[7:6], 3);
      pulse_events(0, 0, 0, 0, 63, 1);
      do_tick();
      chk("R4 mfa at 63 alone", combo_buf[5:0], 63);
      chk("R4 cofa independent", combo_buf[7:6], 1);
      pulse_events(0, 0, 0, 0, 2, 7);
      do_tick();
      chk("R4 mfa unaffected by cofa saturation", combo_buf[5:0], 2);
      chk("R4 cofa at 3", combo_buf[7:6], 3);
   endtask

   task automatic test_req_ignored_periodic();
      mode_dem = 0;
      do_tick();
      pulse_events(6, 0, 0, 0, 0, 0);
      @(negedge clk); req = 1;
      @(negedge clk); req = 0;
      chk("R7 req ignored buf", cv_buf, 0);
      @(negedge clk);
      chk("R7 ack low", ack, 0);
      do_tick();
      chk("R7 count not cleared by req", cv_buf, 6);
   endtask

   task automatic test_demand();
      mode_dem = 1;
      pulse_events(0, 0, 4, 0, 0, 0);
      do_tick();
      chk("R6 tick ignored crc_buf", crc_buf, 0);
      chk("R6 tick ignored cv_buf", cv_buf, 6);
      pulse_events(0, 0, 1, 0, 0, 0);
      @(negedge clk); req = 1; eblk_ev = 1;
      @(negedge clk); req = 0; eblk_ev = 0;
      chk("R6 req copies crc", crc_buf, 5);
      chk("R8 req copy excludes eblk event", eblk_buf, 0);
      chk("R9 ack low after sampling edge", ack, 0);
      @(negedge clk);
      chk("R9 ack high next edge", ack, 1);
      repeat (3) @(negedge clk);
      chk("R9 ack held", ack, 1);
      @(negedge clk); req = 1;
      @(negedge clk); req = 0;
      chk("R9 ack cleared by next req", ack, 0);
      chk("R6 second req cleared crc", crc_buf, 0);
      chk("R8 eblk event kept", eblk_buf, 1);
      @(negedge clk);
      chk("R9 ack rises again", ack, 1);
      mode_dem = 0;
      @(negedge clk);
      chk("R7 ack dropped in periodic mode", ack, 0);
   endtask

   initial begin : watchdog
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      clear_inputs();
      mode_dem = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      test_reset();
      test_periodic();
      test_same_cycle_tick();
      test_saturation();
      test_req_ignored_periodic();
      test_demand();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule